// File: doc/BRIEF.md
# Quadrant LSB Signalling Override

This block sits on the receive data path of one time-division-multiplexed stream. Each channel byte arrives with its channel number and a byte strobe. The block splits the frame into four equal quarters and can force bit 0 of every byte in a chosen quarter to one. This supports bit-robbed signalling. Each quarter has its own enable bit. Where the covering enable is low, the byte passes through untouched.

The size of a quarter follows the stream rate. At the slowest rate the frame has 32 channels and each quarter holds 8 of them. At the middle rate the frame has 64 channels and each quarter holds 16. At the fastest rate the frame has 128 channels and each quarter holds 32. The quarter number is the two channel-number bits just above a quarter's span. The result is registered and appears one clock after the strobe, together with an output valid flag.

Top module: `quad_lsb_override`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `dataOut` is 0 and `dataValid` is 0.
- R2: `dataValid` is high in exactly the cycle that follows a cycle with `byteValid` high. `dataOut` carries the result of that byte in the same cycle.
- R3: Bits 7 down to 1 of `dataOut` always equal bits 7 down to 1 of the byte that was presented.
- R4: With `rateSel` = 2'b00 (32 channels), channels 0–7, 8–15, 16–23 and 24–31 form quarters 0, 1, 2 and 3. `quadEn[k]` governs quarter k.
- R5: With `rateSel` = 2'b01 (64 channels), channels 0–15, 16–31, 32–47 and 48–63 form quarters 0, 1, 2 and 3.
- R6: With `rateSel` = 2'b10 (128 channels), channels 0–31, 32–63, 64–95 and 96–127 form quarters 0, 1, 2 and 3.
- R7: `rateSel` = 2'b11 selects the same quarter boundaries as 2'b00.
- R8: If the enable of the byte's quarter is low, bit 0 passes unchanged, whether it is 0 or 1. If the enable is high, bit 0 of the output is 1.
- R9: `quadEn` is sampled with each byte. A change between two back-to-back bytes applies to the second byte and not to the first.
- R10: While `byteValid` is low, `dataOut` holds its last value, whatever `dataIn` does.
- R11: Channel-number bits above the range of the selected rate are ignored. At 32 channels, channel 40 falls in quarter 1. At 64 channels, channel 100 falls in quarter 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanNum | input | 7 | Channel number of the presented byte |
| byteValid | input | 1 | Strobe: a channel byte is presented this cycle |
| dataIn | input | 8 | Channel byte, bit 0 is the LSB |
| rateSel | input | 2 | 00: 32 ch, 01: 64 ch, 10: 128 ch, 11: as 00 |
| quadEn | input | 4 | Bit k enables the LSB override in quarter k |
| dataOut | output | 8 | Registered, possibly modified byte |
| dataValid | output | 1 | `dataOut` holds a new byte this cycle |

## Verification
Every byte result is due exactly one clock after its strobe, because there is a single register stage between the inputs and the outputs. The bench drives inputs on the falling edge and lowers the strobe on the next falling edge. At that moment it checks `dataOut` and `dataValid`, after the one capturing rising edge. For back-to-back bytes, each result is checked on the falling edge where the next byte is driven. For hold behaviour, the outputs are checked on idle falling edges after `dataIn` has been changed.

// File: rtl/qlsb_pkg.sv
package qlsb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a byte this cycle
    logic forceLsb;  // set bit 0 of the captured byte
  } qlsbStrobe_t;
endpackage

// File: rtl/qlsb_ctrl.sv
module qlsb_ctrl
  import qlsb_pkg::*;
#(
  parameter int CH_W       = 7,
  parameter int NUM_QUAD   = 4,
  parameter int NUM_RATES  = 3,
  parameter int BASE_SHIFT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_W-1:0]     chanNum,
  input  logic                byteValid,
  input  logic [1:0]          rateSel,
  input  logic [NUM_QUAD-1:0] quadEn,
  output qlsbStrobe_t         strobe
);
  localparam int QIDX_W = $clog2(NUM_QUAD);

  logic [QIDX_W-1:0] idxByRate [NUM_RATES];
  logic [QIDX_W-1:0] quadIdx;

  // Each rate doubles the channel count, so the quarter field moves up one bit
  for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
    assign idxByRate[r] = chanNum[BASE_SHIFT + r +: QIDX_W];
  end

  always_comb begin
    quadIdx = idxByRate[0];  // unused encoding falls back to slowest rate
    for (int r = 1; r < NUM_RATES; r++) begin
      if (rateSel == r[1:0]) quadIdx = idxByRate[r];
    end
  end

  assign strobe.load     = byteValid;
  assign strobe.forceLsb = quadEn[quadIdx];

  // R8
  no_enable_no_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quadEn == '0) |-> !strobe.forceLsb);

  // R9
  steady_inputs_steady_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(chanNum) && $stable(rateSel) && $stable(quadEn)) |-> $stable(strobe.forceLsb));
endmodule

// File: rtl/qlsb_datapath.sv
module qlsb_datapath
  import qlsb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  qlsbStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outValid
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) dataOut <= {dataIn[DATA_W-1:1], dataIn[0] | strobe.forceLsb};
    end
  end

  // R2
  valid_follows_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !outValid);

  // R3
  upper_bits_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (dataOut[DATA_W-1:1] == $past(dataIn[DATA_W-1:1])));

  // R8
  forced_lsb_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.forceLsb) |=> dataOut[0]);

  // R8
  lsb_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.forceLsb) |=> (dataOut[0] == $past(dataIn[0])));

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(dataOut));
endmodule

// File: rtl/quad_lsb_override.sv
module quad_lsb_override
  import qlsb_pkg::*;
#(
  parameter int CH_W     = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_QUAD = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_W-1:0]     chanNum,
  input  logic                byteValid,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [1:0]          rateSel,
  input  logic [NUM_QUAD-1:0] quadEn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataValid
);
  localparam int NUM_RATES  = 3;
  localparam int BASE_SHIFT = CH_W - ($clog2(NUM_QUAD) + NUM_RATES - 1);

  qlsbStrobe_t strobe;

  qlsb_ctrl #(
    .CH_W(CH_W), .NUM_QUAD(NUM_QUAD), .NUM_RATES(NUM_RATES), .BASE_SHIFT(BASE_SHIFT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chanNum(chanNum), .byteValid(byteValid),
    .rateSel(rateSel), .quadEn(quadEn), .strobe(strobe)
  );

  qlsb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .dataOut(dataOut), .outValid(dataValid)
  );
endmodule

// File: tb/tb_quad_lsb_override.sv
module tb_quad_lsb_override;
  logic       clk = 1'b0;
  logic       rstN;
  logic [6:0] chanNum;
  logic       byteValid;
  logic [7:0] dataIn;
  logic [1:0] rateSel;
  logic [3:0] quadEn;
  logic [7:0] dataOut;
  logic       dataValid;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  quad_lsb_override dut (
    .clk(clk), .rstN(rstN), .chanNum(chanNum), .byteValid(byteValid),
    .dataIn(dataIn), .rateSel(rateSel), .quadEn(quadEn),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  // {req, rate, chan, enables, byte in, expected byte}
  typedef struct packed {
    logic [3:0] req;
    logic [1:0] rate;
    logic [6:0] ch;
    logic [3:0] en;
    logic [7:0] din;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  2'b00, 7'd5,   4'b0001, 8'hA4, 8'hA5},  // R4 quarter 0 on
    '{4'd4,  2'b00, 7'd8,   4'b0001, 8'hA4, 8'hA4},  // R4 ch 8 is quarter 1
    '{4'd4,  2'b00, 7'd15,  4'b0010, 8'h3C, 8'h3D},  // R4
    '{4'd4,  2'b00, 7'd23,  4'b0100, 8'h00, 8'h01},  // R4
    '{4'd4,  2'b00, 7'd24,  4'b1000, 8'hFE, 8'hFF},  // R4
    '{4'd4,  2'b00, 7'd24,  4'b0111, 8'hFE, 8'hFE},  // R4
    '{4'd5,  2'b01, 7'd15,  4'b0001, 8'h10, 8'h11},  // R5
    '{4'd5,  2'b01, 7'd16,  4'b0001, 8'h10, 8'h10},  // R5
    '{4'd5,  2'b01, 7'd47,  4'b0100, 8'h80, 8'h81},  // R5
    '{4'd5,  2'b01, 7'd48,  4'b1000, 8'h7E, 8'h7F},  // R5
    '{4'd6,  2'b10, 7'd31,  4'b0001, 8'h22, 8'h23},  // R6
    '{4'd6,  2'b10, 7'd32,  4'b0001, 8'h22, 8'h22},  // R6
    '{4'd6,  2'b10, 7'd95,  4'b0100, 8'h44, 8'h45},  // R6
    '{4'd6,  2'b10, 7'd96,  4'b1000, 8'h44, 8'h45},  // R6
    '{4'd6,  2'b10, 7'd127, 4'b0111, 8'h44, 8'h44},  // R6
    '{4'd7,  2'b11, 7'd8,   4'b0010, 8'h50, 8'h51},  // R7
    '{4'd7,  2'b11, 7'd16,  4'b0010, 8'h50, 8'h50},  // R7 would be quarter 1 at 64 ch
    '{4'd11, 2'b00, 7'd40,  4'b0010, 8'h60, 8'h61},  // R11
    '{4'd11, 2'b01, 7'd100, 4'b0100, 8'h60, 8'h61},  // R11
    '{4'd8,  2'b00, 7'd3,   4'b0000, 8'h33, 8'h33},  // R8 LSB 1 kept
    '{4'd8,  2'b00, 7'd3,   4'b0000, 8'h32, 8'h32},  // R8 LSB 0 kept
    '{4'd3,  2'b00, 7'd3,   4'b1111, 8'hEF, 8'hEF}   // R3 upper bits intact
  };

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] r, input logic [6:0] c, input logic [3:0] e,
                       input logic [7:0] d);
    rateSel = r; chanNum = c; quadEn = e; dataIn = d; byteValid = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; byteValid = 1'b0; chanNum = '0; dataIn = 8'hFF; rateSel = '0; quadEn = 4'hF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "dataOut in reset", dataOut, 8'h00);
    check("R1", "dataValid in reset", {7'b0, dataValid}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "dataOut after release", dataOut, 8'h00);
    check("R1", "dataValid after release", {7'b0, dataValid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].rate, VECS[i].ch, VECS[i].en, VECS[i].din);
      @(negedge clk);
      byteValid = 1'b0;
      check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i), dataOut, VECS[i].exp);
      check("R2", "dataValid one cycle after strobe", {7'b0, dataValid}, 8'h01);
    end

    // R10 hold while idle, R2 valid drops
    dataIn = 8'h00; quadEn = 4'hF;
    @(negedge clk);
    check("R10", "hold while idle", dataOut, 8'hEF);
    check("R2", "valid low when idle", {7'b0, dataValid}, 8'h00);
    dataIn = 8'h5A;
    @(negedge clk);
    check("R10", "hold after dataIn change", dataOut, 8'hEF);

    // R9 enable change between back-to-back bytes
    drive(2'b00, 7'd2, 4'b0001, 8'h00);
    @(negedge clk);
    drive(2'b00, 7'd3, 4'b0000, 8'h00);
    check("R9", "first byte uses its own enable", dataOut, 8'h01);
    check("R2", "valid first back-to-back", {7'b0, dataValid}, 8'h01);
    @(negedge clk);
    byteValid = 1'b0;
    check("R9", "second byte uses new enable", dataOut, 8'h00);
    check("R2", "valid second back-to-back", {7'b0, dataValid}, 8'h01);
    @(negedge clk);
    check("R2", "valid drops after burst", {7'b0, dataValid}, 8'h00);

    // R1 reset mid-run clears the output
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "dataOut after mid-run reset", dataOut, 8'h00);
    rstN = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule